// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire serial link. Through it an external host reads and writes a bank of eight byte-wide registers. The link has three lines: a frame enable, a serial clock and one data line that changes direction. The block samples all three lines in its own system clock domain. It decodes the command byte that opens each frame and moves data bits least-significant first. It then issues single-cycle read and write strobes to a register file that sits outside the block.

A frame opens when the enable line goes high and closes when it goes low. The first eight serial clocks carry the command byte. A single-register frame then carries one data byte. A burst frame carries eight data bytes, one per register, in ascending address order.

Write protection comes from one bit of the register file, which the block receives as an input. The block uses that bit to suppress writes, and it never writes the register that holds the bit during a burst. The data line output enable is active only while read data is being shifted out.

Top module: `sreg_serial_port`

## Requirements
- R1: The command byte has the following layout.
  - Bit 0 selects the direction: 1 is a read, 0 is a write.
  - Bits 5:1 hold the address. Values 0 to 7 select one register and 31 selects burst mode.
  - Bits 7:6 are ignored.
  - A frame with any other address issues no strobe and never drives the data line.
- R2: The block samples serial input bits on rising edges of the serial clock, least-significant bit first.
- R3: A single-register write issues exactly one write strobe, on the 16th rising edge, carrying the addressed register and the received byte.
- R4: In a read frame, data bit 0 is driven after the first falling edge that follows the 8th command bit. Each later bit follows on the next falling edge, least-significant first. The block issues one read strobe per byte.
- R5: A burst frame moves registers 0 to 7 in ascending order. The frame takes 72 serial clocks: 8 for the command and 64 for data.
- R6: The block ignores serial clocks beyond the frame length. No further strobes occur and no further bits are driven.
- R7: While bit 7 of register 7 is 1, the block suppresses writes to registers 0 to 6. A single-register write to register 7 is always accepted.
- R8: A burst write never writes register 7.
- R9: Taking the enable line low ends any frame. A partly received byte is not written. The next frame starts with a new command byte.
- R10: The data line output enable rises only at the first read data bit. It falls on the falling edge that follows the end of the frame. It drops combinationally as soon as the enable line goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Frame enable from host, asynchronous |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| sdio_i | input | 1 | Serial data from host |
| sdio_o | output | 1 | Serial data to host |
| sdio_oe_o | output | 1 | Output enable for the data line driver |
| wp_i | input | 1 | Write-protect bit from the register file (bit 7 of register 7) |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_waddr_o | output | 3 | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| reg_re_o | output | 1 | Register read strobe, one cycle |
| reg_raddr_o | output | 3 | Register read address, combinational |
| reg_rdata_i | input | 8 | Register read data, combinational on reg_raddr_o |

## Verification
The bench builds the block with its default parameters: eight registers of eight bits, two synchronizer stages, burst code 31 and write protection held in register 7. With only eight registers, every address can be covered by single-register writes and reads, by full bursts in both directions, and by every rule about the protected register. These cases include frames that carry extra clocks, frames with an invalid address and frames cut short mid-byte. Expected register contents come from arithmetic patterns computed in the bench, and the bench counts write strobes for each frame.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  typedef enum logic [1:0] {
    XF_CMD  = 2'd0,
    XF_RD   = 2'd1,
    XF_WR   = 2'd2,
    XF_SKIP = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= '0;
    else         st_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= '0;
      else         st_q[g] <= st_q[g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sreg_frame_ctl.sv
module sreg_frame_ctl import sreg_pkg::*; #(
  parameter int DW         = 8,
  parameter int NREGS      = 8,
  parameter int BURST_CODE = 31,
  parameter int AW         = $clog2(NREGS),
  parameter int CNT_W      = $clog2(DW * (NREGS + 1) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             din_i,
  output xfer_mode_e       mode_o,
  output logic             burst_o,
  output logic [AW-1:0]    addr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] len_o
);
  localparam int SINGLE_LEN = 2 * DW;
  localparam int BURST_LEN  = DW * (NREGS + 1);
  localparam int CMD_FLD    = 6;  // rw bit + 5 address bits

  xfer_mode_e         mode_q;
  logic               burst_q;
  logic [AW-1:0]      addr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CMD_FLD-1:0] cmd_sh_q;
  logic [CNT_W-1:0]   len;
  xfer_mode_e         dir_mode;

  assign len      = burst_q ? CNT_W'(BURST_LEN) : CNT_W'(SINGLE_LEN);
  assign dir_mode = cmd_sh_q[0] ? XF_RD : XF_WR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= XF_CMD;
      burst_q  <= 1'b0;
      addr_q   <= '0;
      cnt_q    <= '0;
      cmd_sh_q <= '0;
    end else if (!en_i) begin
      mode_q   <= XF_CMD;
      burst_q  <= 1'b0;
      addr_q   <= '0;
      cnt_q    <= '0;
      cmd_sh_q <= '0;
    end else if (rise_i) begin
      if (mode_q == XF_CMD) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q < CNT_W'(CMD_FLD)) cmd_sh_q <= {din_i, cmd_sh_q[CMD_FLD-1:1]};
        if (cnt_q == CNT_W'(DW - 1)) begin
          if (cmd_sh_q[5:1] == 5'(BURST_CODE)) begin
            burst_q <= 1'b1;
            addr_q  <= '0;
            mode_q  <= dir_mode;
          end else if (cmd_sh_q[5:1] < 5'(NREGS)) begin
            addr_q <= cmd_sh_q[AW:1];
            mode_q <= dir_mode;
          end else begin
            mode_q <= XF_SKIP;
          end
        end
      end else if (mode_q != XF_SKIP && cnt_q < len) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign mode_o  = mode_q;
  assign burst_o = burst_q;
  assign addr_o  = addr_q;
  assign cnt_o   = cnt_q;
  assign len_o   = len;

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BURST_LEN));

  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0));

  // R1
  skip_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == XF_SKIP) |-> cnt_q == CNT_W'(DW));
endmodule

// File: rtl/sreg_datapath.sv
module sreg_datapath import sreg_pkg::*; #(
  parameter int DW      = 8,
  parameter int NREGS   = 8,
  parameter int WP_ADDR = 7,
  parameter int AW      = $clog2(NREGS),
  parameter int CNT_W   = $clog2(DW * (NREGS + 1) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             din_i,
  input  xfer_mode_e       mode_i,
  input  logic             burst_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             wp_i,
  input  logic [DW-1:0]    rdata_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [DW-1:0]    wdata_o,
  output logic             re_o,
  output logic [AW-1:0]    raddr_o,
  output logic             dout_o,
  output logic             oe_o
);
  localparam int BP_W = $clog2(DW);

  logic [CNT_W-1:0] data_cnt;
  logic [BP_W-1:0]  bit_pos;
  logic [AW-1:0]    cur_addr;
  logic             in_data, wr_bit, byte_done, wr_ok, rd_fall, rd_end;
  logic [DW-1:0]    rx_word;
  logic [DW-2:0]    rx_sh_q, tx_sh_q;
  logic             we_q, oe_q, dout_q;
  logic [AW-1:0]    waddr_q;
  logic [DW-1:0]    wdata_q;

  assign data_cnt = cnt_i - CNT_W'(DW);
  assign bit_pos  = data_cnt[BP_W-1:0];
  assign cur_addr = burst_i ? AW'(data_cnt >> BP_W) : addr_i;
  assign in_data  = (cnt_i >= CNT_W'(DW)) && (cnt_i < len_i);

  // write path: bits arrive on rising edges
  assign wr_bit    = en_i && rise_i && (mode_i == XF_WR) && in_data;
  assign rx_word   = {din_i, rx_sh_q};
  assign byte_done = wr_bit && (bit_pos == BP_W'(DW - 1));
  // protected register: burst never writes it, single write always does
  assign wr_ok     = (cur_addr == AW'(WP_ADDR)) ? !burst_i : !wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= byte_done && wr_ok;
      if (wr_bit) rx_sh_q <= rx_word[DW-1:1];
      if (byte_done) begin
        waddr_q <= cur_addr;
        wdata_q <= rx_word;
      end
    end
  end

  // read path: bits leave on falling edges
  assign rd_fall = en_i && fall_i && (mode_i == XF_RD) && in_data;
  assign rd_end  = en_i && fall_i && (mode_i == XF_RD) && (cnt_i == len_i);
  assign re_o    = rd_fall && (bit_pos == '0);
  assign raddr_o = cur_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q    <= 1'b0;
      dout_q  <= 1'b0;
      tx_sh_q <= '0;
    end else if (!en_i) begin
      oe_q    <= 1'b0;
      dout_q  <= 1'b0;
      tx_sh_q <= '0;
    end else if (rd_fall) begin
      oe_q <= 1'b1;
      if (bit_pos == '0) begin
        dout_q  <= rdata_i[0];
        tx_sh_q <= rdata_i[DW-1:1];
      end else begin
        dout_q  <= tx_sh_q[0];
        tx_sh_q <= tx_sh_q >> 1;
      end
    end else if (rd_end) begin
      oe_q <= 1'b0;
    end
  end

  assign we_o    = we_q;
  assign waddr_o = waddr_q;
  assign wdata_o = wdata_q;
  assign dout_o  = dout_q;
  assign oe_o    = oe_q;

  // R7
  wp_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && waddr_q != AW'(WP_ADDR)) |-> !$past(wp_i));

  // R8
  burst_wp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && waddr_q == AW'(WP_ADDR)) |-> !$past(burst_i));

  // R10
  oe_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> ($past(mode_i) == XF_RD) && ($past(cnt_i) >= CNT_W'(DW)));

  // R4
  re_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |-> !we_q && en_i);
endmodule

// File: rtl/sreg_serial_port.sv
module sreg_serial_port import sreg_pkg::*; #(
  parameter int DW          = 8,
  parameter int NREGS       = 8,
  parameter int BURST_CODE  = 31,
  parameter int WP_ADDR     = 7,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          sclk_i,
  input  logic          sdio_i,
  output logic          sdio_o,
  output logic          sdio_oe_o,
  input  logic          wp_i,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_waddr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_re_o,
  output logic [AW-1:0] reg_raddr_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int CNT_W = $clog2(DW * (NREGS + 1) + 1);

  logic [2:0]       sync_q;
  logic             ce_s, sclk_s, din_s, sclk_d_q, rise, fall;
  xfer_mode_e       mode;
  logic             burst, oe;
  logic [AW-1:0]    addr;
  logic [CNT_W-1:0] cnt, len;

  sreg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_i, sclk_i, sdio_i}),
    .q_o   (sync_q)
  );
  assign {ce_s, sclk_s, din_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s;
  end
  assign rise = sclk_s && !sclk_d_q;
  assign fall = !sclk_s && sclk_d_q;

  sreg_frame_ctl #(.DW(DW), .NREGS(NREGS), .BURST_CODE(BURST_CODE), .AW(AW), .CNT_W(CNT_W)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ce_s),
    .rise_i (rise),
    .din_i  (din_s),
    .mode_o (mode),
    .burst_o(burst),
    .addr_o (addr),
    .cnt_o  (cnt),
    .len_o  (len)
  );

  sreg_datapath #(.DW(DW), .NREGS(NREGS), .WP_ADDR(WP_ADDR), .AW(AW), .CNT_W(CNT_W)) u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ce_s),
    .rise_i (rise),
    .fall_i (fall),
    .din_i  (din_s),
    .mode_i (mode),
    .burst_i(burst),
    .addr_i (addr),
    .cnt_i  (cnt),
    .len_i  (len),
    .wp_i   (wp_i),
    .rdata_i(reg_rdata_i),
    .we_o   (reg_we_o),
    .waddr_o(reg_waddr_o),
    .wdata_o(reg_wdata_o),
    .re_o   (reg_re_o),
    .raddr_o(reg_raddr_o),
    .dout_o (sdio_o),
    .oe_o   (oe)
  );

  // raw enable gates the driver so release does not wait for the synchronizer
  assign sdio_oe_o = oe && ce_i;

  // R10
  oe_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe && !$past(ce_s)) |-> $past(oe));
endmodule

// File: tb/sreg_serial_port_tb_top.sv
module sreg_serial_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_i = 1'b0, sclk_i = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe_o, wp_i;
  logic reg_we_o, reg_re_o;
  logic [2:0] reg_waddr_o, reg_raddr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;

  logic [7:0] model [8] = '{default: 8'h00};
  logic [7:0] exp_r [8] = '{default: 8'h00};
  logic [7:0] bdat [8];
  logic [7:0] rbuf [8];
  int we_cnt = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sreg_serial_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .wp_i(wp_i),
    .reg_we_o(reg_we_o), .reg_waddr_o(reg_waddr_o), .reg_wdata_o(reg_wdata_o),
    .reg_re_o(reg_re_o), .reg_raddr_o(reg_raddr_o), .reg_rdata_i(reg_rdata_i)
  );

  // register file next to the port
  assign reg_rdata_i = model[reg_raddr_o];
  assign wp_i        = model[7][7];
  always @(posedge clk) if (reg_we_o) begin
    model[reg_waddr_o] <= reg_wdata_o;
    we_cnt <= we_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic din, output logic dout, output logic oe);
    sdio_i = din;
    tick(HALF);
    dout = sdio_o;
    oe   = sdio_oe_o;
    sclk_i = 1'b1;
    tick(HALF);
    sclk_i = 1'b0;
  endtask

  task automatic frame_begin();
    ce_i = 1'b1;
    tick(4);
  endtask

  task automatic frame_end();
    tick(2);
    ce_i = 1'b0;
    tick(6);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb, output logic oe_any);
    logic d, o;
    oe_any = 1'b0;
    for (int i = 0; i < nb; i++) begin
      bit_cycle(b[i], d, o);
      oe_any |= o;
    end
  endtask

  task automatic recv_byte(output logic [7:0] b, output logic oe_all);
    logic d, o;
    oe_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b0, d, o);
      b[i] = d;
      oe_all &= o;
    end
  endtask

  function automatic logic [7:0] cmd(input bit rd, input int a);
    return {2'b00, 5'(a), rd};
  endfunction

  task automatic wr_single(input int a, input logic [7:0] v);
    logic o;
    frame_begin();
    send_bits(cmd(1'b0, a), 8, o);
    send_bits(v, 8, o);
    frame_end();
  endtask

  task automatic rd_single(input int a, output logic [7:0] v, output logic cmd_oe, output logic dat_oe);
    frame_begin();
    send_bits(cmd(1'b1, a), 8, cmd_oe);
    recv_byte(v, dat_oe);
    frame_end();
  endtask

  task automatic burst_wr();
    logic o;
    frame_begin();
    send_bits(cmd(1'b0, 31), 8, o);
    for (int i = 0; i < 8; i++) send_bits(bdat[i], 8, o);
    frame_end();
  endtask

  task automatic burst_rd(output logic all_oe);
    logic o, c;
    all_oe = 1'b1;
    frame_begin();
    send_bits(cmd(1'b1, 31), 8, c);
    for (int i = 0; i < 8; i++) begin
      recv_byte(rbuf[i], o);
      all_oe &= o;
    end
    frame_end();
  endtask

  task automatic check_all_burst(input string req);
    logic oe_ok;
    burst_rd(oe_ok);
    chk(oe_ok, req, oe_ok, 1);
    for (int i = 0; i < 8; i++) chk(rbuf[i] == exp_r[i], req, rbuf[i], exp_r[i]);
  endtask

  initial begin
    int n0;
    logic [7:0] v;
    logic co, dox, o, d;
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    // reset state (R10)
    chk(sdio_oe_o == 1'b0, "R10 reset oe", sdio_oe_o, 0);
    chk(reg_we_o == 1'b0, "R3 reset we", reg_we_o, 0);
    chk(reg_re_o == 1'b0, "R4 reset re", reg_re_o, 0);

    // single writes over every address (R3, R2)
    for (int a = 0; a < 8; a++) begin
      v = (a == 7) ? 8'h15 : 8'(a * 37 + 11);
      n0 = we_cnt;
      wr_single(a, v);
      chk(we_cnt - n0 == 1, "R3 one strobe", we_cnt - n0, 1);
      exp_r[a] = v;
    end
    // single reads over every address (R4, R2, R10)
    for (int a = 0; a < 8; a++) begin
      rd_single(a, v, co, dox);
      chk(v == exp_r[a], "R4 R2 single read", v, exp_r[a]);
      chk(!co && dox, "R10 oe window", {co, dox}, 2'b01);
    end

    // burst write skips register 7 (R5, R8)
    for (int i = 0; i < 8; i++) bdat[i] = 8'hA0 ^ 8'(i * 13);
    n0 = we_cnt;
    burst_wr();
    chk(we_cnt - n0 == 7, "R8 burst strobes", we_cnt - n0, 7);
    for (int i = 0; i < 7; i++) exp_r[i] = bdat[i];
    check_all_burst("R5 burst read");

    // extra clocks ignored (R6)
    n0 = we_cnt;
    frame_begin();
    send_bits(cmd(1'b0, 2), 8, o);
    send_bits(8'h5A, 8, o);
    send_bits(8'hFF, 8, o);
    frame_end();
    chk(we_cnt - n0 == 1, "R6 extra write clocks", we_cnt - n0, 1);
    exp_r[2] = 8'h5A;
    frame_begin();
    send_bits(cmd(1'b1, 2), 8, o);
    recv_byte(v, dox);
    bit_cycle(1'b0, d, o);
    chk(v == 8'h5A, "R6 read value", v, 8'h5A);
    chk(o == 1'b0, "R10 R6 oe after frame", o, 0);
    frame_end();

    // high command bits ignored (R1)
    n0 = we_cnt;
    frame_begin();
    send_bits(8'hC0 | cmd(1'b0, 3), 8, o);
    send_bits(8'h3C, 8, o);
    frame_end();
    chk(we_cnt - n0 == 1, "R1 bits 7:6 ignored", we_cnt - n0, 1);
    exp_r[3] = 8'h3C;

    // invalid address (R1)
    n0 = we_cnt;
    wr_single(12, 8'hFF);
    chk(we_cnt - n0 == 0, "R1 invalid write", we_cnt - n0, 0);
    frame_begin();
    send_bits(cmd(1'b1, 12), 8, o);
    send_bits(8'h00, 8, o);
    frame_end();
    chk(o == 1'b0, "R1 invalid read oe", o, 0);
    check_all_burst("R1 contents");

    // write protection (R7, R8)
    n0 = we_cnt;
    wr_single(7, 8'h80);
    chk(we_cnt - n0 == 1, "R7 set protect", we_cnt - n0, 1);
    exp_r[7] = 8'h80;
    n0 = we_cnt;
    wr_single(1, 8'h33);
    chk(we_cnt - n0 == 0, "R7 blocked single", we_cnt - n0, 0);
    for (int i = 0; i < 8; i++) bdat[i] = 8'h0F + 8'(i);
    n0 = we_cnt;
    burst_wr();
    chk(we_cnt - n0 == 0, "R7 R8 blocked burst", we_cnt - n0, 0);
    check_all_burst("R7 contents");
    n0 = we_cnt;
    wr_single(7, 8'h01);
    chk(we_cnt - n0 == 1, "R7 clear protect", we_cnt - n0, 1);
    exp_r[7] = 8'h01;
    wr_single(1, 8'h33);
    exp_r[1] = 8'h33;

    // termination (R9, R10)
    n0 = we_cnt;
    frame_begin();
    send_bits(cmd(1'b0, 4), 8, o);
    send_bits(8'hEE, 4, o);
    frame_end();
    chk(we_cnt - n0 == 0, "R9 partial single", we_cnt - n0, 0);
    n0 = we_cnt;
    frame_begin();
    send_bits(cmd(1'b0, 31), 8, o);
    send_bits(8'h11, 8, o);
    send_bits(8'h22, 8, o);
    send_bits(8'h33, 8, o);
    send_bits(8'h44, 2, o);
    frame_end();
    chk(we_cnt - n0 == 3, "R9 partial burst", we_cnt - n0, 3);
    exp_r[0] = 8'h11; exp_r[1] = 8'h22; exp_r[2] = 8'h33;
    frame_begin();
    send_bits(cmd(1'b1, 0), 8, o);
    for (int i = 0; i < 3; i++) bit_cycle(1'b0, d, o);
    chk(o == 1'b1, "R10 oe mid read", o, 1);
    tick(2);
    ce_i = 1'b0;
    #1;
    chk(sdio_oe_o == 1'b0, "R10 immediate release", sdio_oe_o, 0);
    tick(6);
    check_all_burst("R9 after abort");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule